// File: doc/BRIEF.md
# Flash Line Buffer Read Controller

This block sits between a 64-bit bus slave port and a slow non-volatile array that delivers 128-bit lines. Repeated and sequential reads complete without wait states. The block serves bus reads and decides whether each one hits. On a miss it starts an array read and stores the returned line. Each read returns the 64-bit half of the line that the address selects.

The address space has two banks, chosen by the top address bit. The code bank keeps four line buffers and replaces them in least-recently-used order. After a code miss it can speculatively fetch the next line. The data bank keeps a single line register and never fetches ahead. Each bank has its own array access time, set by an input.

The array is addressed one line at a time. The controller raises a one-cycle strobe and holds the line address for the configured number of cycles. It then captures the line. Writes only invalidate stale lines. Programming, erase and error correction belong to other blocks.

Top module: `flb_line_buf`

## Requirements
- R1: After reset `req_ready` is high, `rsp_valid` is low, no array strobe is raised and every buffer is empty.
- R2: A code-bank read (address bit 19 = 0) whose line is not buffered is answered `code_wait` clock edges after acceptance. This is `code_wait` wait states beyond a hit. It raises exactly one `code_rd` pulse. The read returns line bits 63:0 when address bit 3 is 0 and bits 127:64 when it is 1.
- R3: A read to a line held in a valid code buffer is answered in the cycle after acceptance (zero wait states). It returns the addressed half and raises no array strobe.
- R4: The code bank holds four lines. A fill replaces the buffer used least recently, where both hits and fills count as a use.
- R5: When `pf_en` is high, a completed code-bank miss triggers a fetch of the next line into the least-recently-used buffer. This happens unless that line is already buffered or lies in the data bank. A later read of that line then has zero wait states.
- R6: During a prefetch, a read to the line being prefetched waits for that fetch with fewer than `code_wait` wait states and raises no second strobe. A read to another missing line is held and fetched once the prefetch ends. Only one array fetch is in flight at a time.
- R7: With `pf_en` low, a code miss fetches only the demanded line.
- R8: The data bank (address bit 19 = 1) holds one line register. A read that hits it has zero wait states. A miss replaces it after `data_wait` wait states through one `data_rd` pulse. The data bank never prefetches.
- R9: The wait settings of the two banks act independently. Each is taken when a fetch runs, and a setting of 0 acts as 1.
- R10: A write of size code 2 to a word-aligned address is answered in the next cycle without error. Any buffer or register that holds that line is invalidated, so the next read of the line misses.
- R11: A one-cycle pulse on `inv_valid` invalidates every buffer holding the line of `inv_addr` and leaves other lines valid.
- R12: Size codes are 0 byte, 1 halfword, 2 word and 3 reserved. The following are answered in the next cycle with `rsp_err` high: a halfword at byte offset 3 of its word, a word not aligned to 4 bytes, size code 3, and any write other than an aligned word. They start no array read and change no buffer.
- R13: Byte reads, and halfword reads at byte offsets 0 to 2 of a word, are served normally and return the full addressed 64-bit half.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| pf_en | input | 1 | Enables next-line fetch on the code bank |
| code_wait | input | 4 | Code bank array access time in cycles |
| data_wait | input | 4 | Data bank array access time in cycles |
| req_valid | input | 1 | Bus request present |
| req_ready | output | 1 | Request is accepted at this clock edge |
| req_write | input | 1 | Request is a write |
| req_addr | input | 20 | Byte address |
| req_size | input | 2 | Size code (0 byte, 1 half, 2 word, 3 reserved) |
| rsp_valid | output | 1 | One-cycle response strobe |
| rsp_err | output | 1 | Error response |
| rsp_rdata | output | 64 | Addressed half of the line |
| inv_valid | input | 1 | Invalidate the line of inv_addr |
| inv_addr | input | 20 | Address to invalidate |
| code_rd | output | 1 | Code array fetch start strobe |
| code_line | output | 16 | Line address presented to the code array |
| code_rdata | input | 128 | Code array line data |
| data_rd | output | 1 | Data array fetch start strobe |
| data_line | output | 16 | Line address presented to the data array |
| data_rdata | input | 128 | Data array line data |

## Verification
Hits, writes and error responses fall due on the first clock edge after acceptance. A miss falls due exactly `code_wait` or `data_wait` edges after acceptance. A read that joins a prefetch falls due when that prefetch ends, and a held miss falls due a full access time after the prefetch ends. The bench drives and samples on the falling edge. It counts the falling edges between acceptance and the response strobe and compares that count with these figures. It also counts array strobes, which shows that no fetch was repeated or added.

// File: rtl/flb_pkg.sv
package flb_pkg;

    typedef enum logic [1:0] {
        ST_IDLE  = 2'd0,
        ST_FETCH = 2'd1,
        ST_PF    = 2'd2
    } fsm_e;

    localparam logic [1:0] SZ_BYTE = 2'd0;
    localparam logic [1:0] SZ_HALF = 2'd1;
    localparam logic [1:0] SZ_WORD = 2'd2;
    localparam logic [1:0] SZ_RSVD = 2'd3;

endpackage

// File: rtl/flb_req_check.sv
module flb_req_check
    import flb_pkg::*;
(
    input  logic [1:0] lo_addr,
    input  logic [1:0] size,
    input  logic       wr,
    output logic       err
);
    // R12: accesses leaving their 32-bit container and non-word writes fail
    always_comb begin
        case (size)
            SZ_BYTE: err = wr;
            SZ_HALF: err = wr || (lo_addr == 2'd3);
            SZ_WORD: err = (lo_addr != 2'd0);
            default: err = 1'b1;
        endcase
    end
endmodule

// File: rtl/flb_lookup.sv
module flb_lookup #(
    parameter int NBUF  = 4,
    parameter int LW    = 16,
    parameter int IDX_W = 2
) (
    input  logic [NBUF-1:0]         vld,
    input  logic [NBUF-1:0][LW-1:0] tag,
    input  logic [LW-1:0]           line,
    output logic                    hit,
    output logic [IDX_W-1:0]        idx
);
    logic [NBUF-1:0] match;

    for (genvar g = 0; g < NBUF; g++) begin : g_cmp
        assign match[g] = vld[g] && (tag[g] == line);
    end

    always_comb begin
        hit = |match;
        idx = '0;
        for (int i = NBUF - 1; i >= 0; i--) begin
            if (match[i]) idx = IDX_W'(i);
        end
    end
endmodule

// File: rtl/flb_lru.sv
module flb_lru #(
    parameter int NBUF  = 4,
    parameter int IDX_W = 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             touch,
    input  logic [IDX_W-1:0] touch_idx,
    output logic [IDX_W-1:0] lru_idx
);
    // age 0 is most recent, NBUF-1 is the victim; ages stay a permutation
    logic [NBUF-1:0][IDX_W-1:0] age_d, age_q;

    always_comb begin
        age_d = age_q;
        if (touch) begin
            for (int i = 0; i < NBUF; i++) begin
                if (IDX_W'(i) == touch_idx) begin
                    age_d[i] = '0;
                end else if (age_q[i] < age_q[touch_idx]) begin
                    age_d[i] = age_q[i] + IDX_W'(1);
                end
            end
        end
        lru_idx = '0;
        for (int i = 0; i < NBUF; i++) begin
            if (age_q[i] == IDX_W'(NBUF - 1)) lru_idx = IDX_W'(i);
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            for (int i = 0; i < NBUF; i++) age_q[i] <= IDX_W'(i);
        end else begin
            age_q <= age_d;
        end
    end
endmodule

// File: rtl/flb_line_buf.sv
module flb_line_buf
    import flb_pkg::*;
#(
    parameter int  AW     = 20,
    parameter int  NBUF   = 4,
    parameter int  LINE_W = 128,
    parameter int  BUS_W  = 64,
    parameter int  WAIT_W = 4,
    localparam int OFF_W  = $clog2(LINE_W / 8),
    localparam int LW     = AW - OFF_W
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              pf_en,
    input  logic [WAIT_W-1:0] code_wait,
    input  logic [WAIT_W-1:0] data_wait,
    input  logic              req_valid,
    output logic              req_ready,
    input  logic              req_write,
    input  logic [AW-1:0]     req_addr,
    input  logic [1:0]        req_size,
    output logic              rsp_valid,
    output logic              rsp_err,
    output logic [BUS_W-1:0]  rsp_rdata,
    input  logic              inv_valid,
    input  logic [AW-1:0]     inv_addr,
    output logic              code_rd,
    output logic [LW-1:0]     code_line,
    input  logic [LINE_W-1:0] code_rdata,
    output logic              data_rd,
    output logic [LW-1:0]     data_line,
    input  logic [LINE_W-1:0] data_rdata
);
    localparam int BYTE_W = $clog2(BUS_W / 8);
    localparam int HSEL_W = OFF_W - BYTE_W;
    localparam int IDX_W  = $clog2(NBUF);

    typedef struct packed {
        fsm_e                          st;
        logic [WAIT_W-1:0]             cnt;
        logic                          bank;
        logic [LW-1:0]                 fline;
        logic [HSEL_W-1:0]             fhalf;
        logic                          dmd;
        logic                          kill;
        logic                          pend_v;
        logic                          pend_bank;
        logic [LW-1:0]                 pend_line;
        logic [HSEL_W-1:0]             pend_half;
        logic [NBUF-1:0]               vld;
        logic [NBUF-1:0][LW-1:0]       tag;
        logic [NBUF-1:0][LINE_W-1:0]   dat;
        logic                          hvld;
        logic [LW-1:0]                 htag;
        logic [LINE_W-1:0]             hdat;
        logic                          rsp_v;
        logic                          rsp_e;
        logic [BUS_W-1:0]              rsp_d;
        logic                          crd;
        logic                          drd;
    } state_t;

    state_t d, q;

    logic [LW-1:0]     req_line, inv_line, pf_line;
    logic              req_bank;
    logic [HSEL_W-1:0] req_half;
    logic              rq_err, rhit, phit;
    logic [IDX_W-1:0]  ridx, pidx, lru_idx;
    logic [WAIT_W-1:0] cur_wait, lat_m1;
    logic              busy, last, fill_now, acc, kill_now, pf_ok;
    logic              touch;
    logic [IDX_W-1:0]  touch_idx;
    logic [LINE_W-1:0] fill_line;
    logic              unused_bits;

    assign req_line = req_addr[AW-1:OFF_W];
    assign req_bank = req_addr[AW-1];
    assign req_half = req_addr[OFF_W-1:BYTE_W];
    assign inv_line = inv_addr[AW-1:OFF_W];
    assign pf_line  = q.fline + LW'(1);
    assign unused_bits = ^{req_addr[BYTE_W-1:0], inv_addr[OFF_W-1:0], pidx};

    flb_req_check u_check (
        .lo_addr (req_addr[1:0]),
        .size    (req_size),
        .wr      (req_write),
        .err     (rq_err)
    );

    flb_lookup #(.NBUF(NBUF), .LW(LW), .IDX_W(IDX_W)) u_req_lookup (
        .vld  (q.vld),
        .tag  (q.tag),
        .line (req_line),
        .hit  (rhit),
        .idx  (ridx)
    );

    flb_lookup #(.NBUF(NBUF), .LW(LW), .IDX_W(IDX_W)) u_pf_lookup (
        .vld  (q.vld),
        .tag  (q.tag),
        .line (pf_line),
        .hit  (phit),
        .idx  (pidx)
    );

    flb_lru #(.NBUF(NBUF), .IDX_W(IDX_W)) u_lru (
        .clk       (clk),
        .rst_n     (rst_n),
        .touch     (touch),
        .touch_idx (touch_idx),
        .lru_idx   (lru_idx)
    );

    always_comb begin
        cur_wait  = q.bank ? data_wait : code_wait;
        lat_m1    = (cur_wait == '0) ? '0 : cur_wait - WAIT_W'(1);
        busy      = (q.st != ST_IDLE);
        last      = busy && (q.cnt == lat_m1);
        fill_now  = last;
        req_ready = (q.st == ST_IDLE) || ((q.st == ST_PF) && !q.pend_v && !last);
        acc       = req_valid && req_ready;
        kill_now  = q.kill || (inv_valid && (inv_line == q.fline));
        fill_line = q.bank ? data_rdata : code_rdata;
        pf_ok     = pf_en && !q.bank && !pf_line[LW-1] && !phit;
        touch     = (acc && !rq_err && !req_write && !req_bank && rhit)
                  || (fill_now && !q.bank && !kill_now);
        touch_idx = fill_now ? lru_idx : ridx;
    end

    always_comb begin
        d       = q;
        d.rsp_v = 1'b0;
        d.rsp_e = 1'b0;
        d.rsp_d = '0;
        d.crd   = 1'b0;
        d.drd   = 1'b0;

        // explicit invalidate
        if (inv_valid) begin
            for (int i = 0; i < NBUF; i++) begin
                if (q.tag[i] == inv_line) d.vld[i] = 1'b0;
            end
            if (q.htag == inv_line) d.hvld = 1'b0;
            if (busy && (q.fline == inv_line)) d.kill = 1'b1;
        end

        if (acc) begin
            if (rq_err) begin
                d.rsp_v = 1'b1;
                d.rsp_e = 1'b1;
            end else if (req_write) begin
                d.rsp_v = 1'b1;
                for (int i = 0; i < NBUF; i++) begin
                    if (q.tag[i] == req_line) d.vld[i] = 1'b0;
                end
                if (q.htag == req_line) d.hvld = 1'b0;
                if (busy && (q.fline == req_line)) d.kill = 1'b1;
            end else if (!req_bank && rhit) begin
                d.rsp_v = 1'b1;
                d.rsp_d = q.dat[ridx][int'(req_half)*BUS_W +: BUS_W];
            end else if (req_bank && q.hvld && (q.htag == req_line)) begin
                d.rsp_v = 1'b1;
                d.rsp_d = q.hdat[int'(req_half)*BUS_W +: BUS_W];
            end else if (q.st == ST_IDLE) begin
                d.st    = ST_FETCH;
                d.cnt   = '0;
                d.bank  = req_bank;
                d.fline = req_line;
                d.fhalf = req_half;
                d.dmd   = 1'b1;
                d.kill  = 1'b0;
                d.crd   = !req_bank;
                d.drd   = req_bank;
            end else if (!req_bank && (req_line == q.fline)) begin
                // join the prefetch already under way
                d.dmd   = 1'b1;
                d.fhalf = req_half;
            end else begin
                d.pend_v    = 1'b1;
                d.pend_bank = req_bank;
                d.pend_line = req_line;
                d.pend_half = req_half;
            end
        end

        if (busy) begin
            if (!last) begin
                d.cnt = q.cnt + WAIT_W'(1);
            end else begin
                d.cnt  = '0;
                d.dmd  = 1'b0;
                d.kill = 1'b0;
                if (!kill_now) begin
                    if (q.bank) begin
                        d.hvld = 1'b1;
                        d.htag = q.fline;
                        d.hdat = fill_line;
                    end else begin
                        d.vld[lru_idx] = 1'b1;
                        d.tag[lru_idx] = q.fline;
                        d.dat[lru_idx] = fill_line;
                    end
                end
                if (q.dmd) begin
                    d.rsp_v = 1'b1;
                    d.rsp_d = fill_line[int'(q.fhalf)*BUS_W +: BUS_W];
                end
                if ((q.st == ST_FETCH) && pf_ok) begin
                    d.st    = ST_PF;
                    d.bank  = 1'b0;
                    d.fline = pf_line;
                    d.crd   = 1'b1;
                end else if (q.pend_v) begin
                    d.st     = ST_FETCH;
                    d.bank   = q.pend_bank;
                    d.fline  = q.pend_line;
                    d.fhalf  = q.pend_half;
                    d.dmd    = 1'b1;
                    d.pend_v = 1'b0;
                    d.crd    = !q.pend_bank;
                    d.drd    = q.pend_bank;
                end else begin
                    d.st = ST_IDLE;
                end
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) q <= '0;
        else        q <= d;
    end

    assign rsp_valid = q.rsp_v;
    assign rsp_err   = q.rsp_e;
    assign rsp_rdata = q.rsp_d;
    assign code_rd   = q.crd;
    assign data_rd   = q.drd;
    assign code_line = q.fline;
    assign data_line = q.fline;
endmodule

// File: rtl/flb_chk.sv
module flb_chk
    import flb_pkg::*;
#(
    parameter int AW     = 20,
    parameter int LW     = 16,
    parameter int WAIT_W = 4
) (
    input logic              clk,
    input logic              rst_n,
    input logic              req_valid,
    input logic              req_ready,
    input logic              req_write,
    input logic [AW-1:0]     req_addr,
    input logic [1:0]        req_size,
    input logic              rsp_valid,
    input logic              rsp_err,
    input logic              code_rd,
    input logic [LW-1:0]     code_line,
    input logic [WAIT_W-1:0] code_wait,
    input logic              data_rd
);
    // R12
    err_rsp_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && req_ready && req_size == SZ_RSVD) |=> (rsp_valid && rsp_err));

    // R10
    wr_done_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && req_ready && req_write && req_size == SZ_WORD && req_addr[1:0] == 2'd0)
        |=> (rsp_valid && !rsp_err));

    // R2
    line_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (code_rd && code_wait > WAIT_W'(1)) |=> $stable(code_line));

    // R8
    no_pf_data_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && req_ready && !req_write && req_addr[AW-1]) |=> !code_rd);

    // R6
    one_rd_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !(code_rd && data_rd));
endmodule

bind flb_line_buf flb_chk #(.AW(AW), .LW(LW), .WAIT_W(WAIT_W)) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .req_valid (req_valid),
    .req_ready (req_ready),
    .req_write (req_write),
    .req_addr  (req_addr),
    .req_size  (req_size),
    .rsp_valid (rsp_valid),
    .rsp_err   (rsp_err),
    .code_rd   (code_rd),
    .code_line (code_line),
    .code_wait (code_wait),
    .data_rd   (data_rd)
);

// File: tb/flb_line_buf_tb.sv
module flb_line_buf_tb;
    logic         clk = 1'b0;
    logic         rst_n = 1'b0;
    logic         pf_en = 1'b0;
    logic [3:0]   code_wait = 4'd3;
    logic [3:0]   data_wait = 4'd5;
    logic         req_valid = 1'b0;
    logic         req_ready;
    logic         req_write = 1'b0;
    logic [19:0]  req_addr = '0;
    logic [1:0]   req_size = 2'd2;
    logic         rsp_valid, rsp_err;
    logic [63:0]  rsp_rdata;
    logic         inv_valid = 1'b0;
    logic [19:0]  inv_addr = '0;
    logic         code_rd, data_rd;
    logic [15:0]  code_line, data_line;
    logic [127:0] code_rdata, data_rdata;

    int n_chk = 0;
    int n_bad = 0;
    int crd_n = 0;
    int drd_n = 0;

    always #5 clk = ~clk;

    function automatic logic [31:0] wv(input logic [15:0] ln, input logic [1:0] k);
        return 32'h5A00_0000 ^ {ln, 14'h0, k};
    endfunction

    function automatic logic [127:0] mk_line(input logic [15:0] ln);
        return {wv(ln, 2'd3), wv(ln, 2'd2), wv(ln, 2'd1), wv(ln, 2'd0)};
    endfunction

    function automatic logic [63:0] exp_half(input logic [19:0] a);
        return a[3] ? {wv(a[19:4], 2'd3), wv(a[19:4], 2'd2)}
                    : {wv(a[19:4], 2'd1), wv(a[19:4], 2'd0)};
    endfunction

    // fixed-latency array model: line data is a function of the held line address
    assign code_rdata = mk_line(code_line);
    assign data_rdata = mk_line(data_line);

    always @(negedge clk) begin
        if (code_rd) crd_n++;
        if (data_rd) drd_n++;
    end

    flb_line_buf u_dut (
        .clk(clk), .rst_n(rst_n), .pf_en(pf_en),
        .code_wait(code_wait), .data_wait(data_wait),
        .req_valid(req_valid), .req_ready(req_ready), .req_write(req_write),
        .req_addr(req_addr), .req_size(req_size),
        .rsp_valid(rsp_valid), .rsp_err(rsp_err), .rsp_rdata(rsp_rdata),
        .inv_valid(inv_valid), .inv_addr(inv_addr),
        .code_rd(code_rd), .code_line(code_line), .code_rdata(code_rdata),
        .data_rd(data_rd), .data_line(data_line), .data_rdata(data_rdata)
    );

    task automatic ck(input string tag, input logic [63:0] act, input logic [63:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s: actual %h expected %h", tag, act, exp);
        end
    endtask

    task automatic idle(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic xfer(input logic wr, input logic [19:0] a, input logic [1:0] sz,
                        output logic e, output logic [63:0] dt, output int w);
        int guard;
        @(negedge clk);
        req_valid = 1'b1; req_write = wr; req_addr = a; req_size = sz;
        guard = 0;
        while (!req_ready && guard < 200) begin
            @(negedge clk);
            guard++;
        end
        @(posedge clk);
        @(negedge clk);
        req_valid = 1'b0;
        w = 0;
        while (!rsp_valid && w < 200) begin
            @(negedge clk);
            w++;
        end
        if (guard >= 200 || w >= 200) begin
            n_chk++; n_bad++;
            $display("FAIL timeout at addr %h: actual no response expected response", a);
        end
        e = rsp_err;
        dt = rsp_rdata;
    endtask

    task automatic rd(input logic [19:0] a, input logic [1:0] sz, input int expw, input string tag);
        logic e; logic [63:0] dt; int w;
        xfer(1'b0, a, sz, e, dt, w);
        ck({tag, " data"}, dt, exp_half(a));
        ck({tag, " waits"}, 64'(w), 64'(expw));
        ck({tag, " err"}, 64'(e), 64'd0);
    endtask

    task automatic wr_err(input logic wr, input logic [19:0] a, input logic [1:0] sz, input string tag);
        logic e; logic [63:0] dt; int w;
        xfer(wr, a, sz, e, dt, w);
        ck({tag, " err"}, 64'(e), 64'd1);
        ck({tag, " waits"}, 64'(w), 64'd0);
    endtask

    task automatic pulse_inv(input logic [19:0] a);
        @(negedge clk);
        inv_valid = 1'b1; inv_addr = a;
        @(negedge clk);
        inv_valid = 1'b0;
    endtask

    task automatic t_reset();
        @(negedge clk);
        ck("R1 ready after reset", 64'(req_ready), 64'd1);
        ck("R1 no response after reset", 64'(rsp_valid), 64'd0);
        ck("R1 no array read after reset", 64'(crd_n + drd_n), 64'd0);
    endtask

    task automatic t_miss_hit();
        int c0 = crd_n;
        rd(20'h00100, 2'd2, 3, "R2 code miss");
        ck("R2 one fetch", 64'(crd_n - c0), 64'd1);
        rd(20'h00108, 2'd2, 0, "R3 hit upper half");
        rd(20'h00104, 2'd2, 0, "R3 hit lower half");
        rd(20'h00101, 2'd1, 0, "R13 half at offset 1");
        rd(20'h0010F, 2'd0, 0, "R13 byte read");
        ck("R3 hits fetch nothing", 64'(crd_n - c0), 64'd1);
    endtask

    task automatic t_lru();
        for (int i = 0; i < 4; i++) rd(20'h00200 + 20'(i * 16), 2'd2, 3, "R4 fill");
        rd(20'h00200, 2'd2, 0, "R4 touch first");
        rd(20'h00240, 2'd2, 3, "R4 fifth line evicts oldest");
        rd(20'h00220, 2'd2, 0, "R4 kept line C");
        rd(20'h00230, 2'd2, 0, "R4 kept line D");
        rd(20'h00200, 2'd2, 0, "R4 kept touched line");
        rd(20'h00240, 2'd2, 0, "R4 kept new line");
        rd(20'h00210, 2'd2, 3, "R4 evicted line misses");
    endtask

    task automatic t_pf();
        int c0 = crd_n;
        rd(20'h00300, 2'd2, 3, "R7 miss without prefetch");
        idle(10);
        ck("R7 no prefetch fetch", 64'(crd_n - c0), 64'd1);
        rd(20'h00310, 2'd2, 3, "R7 next line still misses");
        pf_en = 1'b1;
        c0 = crd_n;
        rd(20'h00400, 2'd2, 3, "R5 miss with prefetch");
        idle(10);
        ck("R5 prefetch issued", 64'(crd_n - c0), 64'd2);
        rd(20'h00418, 2'd2, 0, "R5 prefetched line hits");
    endtask

    task automatic t_join();
        logic e; logic [63:0] dt; int w;
        int c0 = crd_n;
        rd(20'h00500, 2'd2, 3, "R6 demand miss");
        xfer(1'b0, 20'h00510, 2'd2, e, dt, w);
        ck("R6 joined data", dt, exp_half(20'h00510));
        ck("R6 joined waits below code_wait", 64'(w >= 1 && w <= 2), 64'd1);
        idle(10);
        ck("R6 no refetch", 64'(crd_n - c0), 64'd2);
        c0 = crd_n;
        rd(20'h00600, 2'd2, 3, "R6 second miss");
        xfer(1'b0, 20'h00708, 2'd2, e, dt, w);
        ck("R6 held miss data", dt, exp_half(20'h00708));
        ck("R6 held miss waits", 64'(w >= 3), 64'd1);
        idle(10);
        ck("R6 fetch count", 64'(crd_n - c0), 64'd4);
    endtask

    task automatic t_data();
        int c0 = crd_n;
        int d0 = drd_n;
        rd(20'h80100, 2'd2, 5, "R8 data miss");
        rd(20'h80108, 2'd2, 0, "R8 data hit");
        rd(20'h80110, 2'd2, 5, "R8 data replace");
        rd(20'h80100, 2'd2, 5, "R8 single register");
        idle(10);
        ck("R8 no code fetch", 64'(crd_n - c0), 64'd0);
        ck("R8 no data prefetch", 64'(drd_n - d0), 64'd3);
        pf_en = 1'b0;
        code_wait = 4'd2;
        rd(20'h00900, 2'd2, 2, "R9 code wait 2");
        data_wait = 4'd0;
        rd(20'h80900, 2'd2, 1, "R9 data wait 0 acts as 1");
        code_wait = 4'd3;
        data_wait = 4'd5;
    endtask

    task automatic t_write();
        logic e; logic [63:0] dt; int w;
        int c0;
        rd(20'h00A00, 2'd2, 3, "R10 fill");
        c0 = crd_n;
        xfer(1'b1, 20'h00A04, 2'd2, e, dt, w);
        ck("R10 write ok", 64'(e), 64'd0);
        ck("R10 write waits", 64'(w), 64'd0);
        ck("R10 write fetches nothing", 64'(crd_n - c0), 64'd0);
        rd(20'h00A00, 2'd2, 3, "R10 written line misses");
    endtask

    task automatic t_inv();
        rd(20'h00B00, 2'd2, 3, "R11 fill");
        pulse_inv(20'h00C00);
        rd(20'h00B08, 2'd2, 0, "R11 other line kept");
        pulse_inv(20'h00B08);
        rd(20'h00B00, 2'd2, 3, "R11 invalidated line misses");
    endtask

    task automatic t_err();
        int c0 = crd_n;
        wr_err(1'b0, 20'h00B03, 2'd1, "R12 half crossing");
        wr_err(1'b0, 20'h00B02, 2'd2, "R12 word unaligned");
        wr_err(1'b0, 20'h00B00, 2'd3, "R12 reserved size");
        wr_err(1'b1, 20'h00B00, 2'd1, "R12 half write");
        wr_err(1'b1, 20'h00B01, 2'd2, "R12 unaligned write");
        ck("R12 no fetch on error", 64'(crd_n - c0), 64'd0);
        rd(20'h00B00, 2'd2, 0, "R12 line untouched");
    endtask

    initial begin
        repeat (300000) @(posedge clk);
        n_chk++; n_bad++;
        $display("FAIL watchdog: actual hung expected finished");
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end

    initial begin
        repeat (4) @(posedge clk);
        @(negedge clk);
        rst_n = 1'b1;
        t_reset();
        t_miss_hit();
        t_lru();
        t_pf();
        t_join();
        t_data();
        t_write();
        t_inv();
        t_err();
        idle(5);
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end
endmodule